// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is the output stage that sits behind each sum term of a programmable AND-OR array. A parameterised vector of product-term results is ORed into one sum. The sum then takes one of two paths. It can be captured in a D flip-flop on the rising clock edge, or it can go straight to the output. A polarity stage then either passes the value unchanged or inverts it, and the result drives one pin. Each pin has its own enable, driven by a separate product term that is not part of the sum.

The cell sends one feedback bit back to the array, in true and complemented form. In registered mode the feedback comes from the inverted flip-flop output, so the pin cannot act as an input. In combinational mode the feedback is the level on the pin side of the output buffer. When the buffer is disabled, that level is whatever the outside world drives, so the pin can serve as an input or as a bidirectional line.

Two array-wide product terms act on the flip-flop state ahead of the polarity stage. One clears it at once. The other sets it on the next rising edge. A synchronous reset input also clears the register. The pin is modelled as three separate wires: the driven level, the enable, and the externally observed level.

Top module: `pal_out_cell`

## Requirements
- R1: The sum is the OR of all NUM_PT logic product terms, including the highest-numbered bit. NUM_PT may be 8, 10, 12, 14 or 16, and any other value is rejected at elaboration.
- R2: With cfg_s1=0 (registered), the flip-flop loads the sum on each rising clock edge, and pin_out reflects the register rather than the live sum.
- R3: With cfg_s1=1 (combinational), pin_out follows the sum in the same cycle, with no clock edge in between.
- R4: cfg_s0=1 drives the value to pin_out unchanged (active high). cfg_s0=0 drives its inverse (active low). This holds in both modes.
- R5: pin_oe always equals oe_pterm and does not depend on the logic product terms.
- R6: A high areset_pterm clears the flip-flop at once, without waiting for a clock edge. In registered mode pin_out then reads 0 when active high and 1 when active low.
- R7: A high spreset_pterm sets the flip-flop to 1 on the next rising edge, and not before that edge.
- R8: When areset_pterm and spreset_pterm are both high, the flip-flop stays at 0.
- R9: A high rst at a rising edge clears the flip-flop, and rst takes priority over spreset_pterm.
- R10: In registered mode, fb_true equals the inverse of the flip-flop state, and pin_in has no effect on it.
- R11: In combinational mode, fb_true equals pin_out while pin_oe is high, and equals pin_in while pin_oe is low.
- R12: fb_comp is always the inverse of fb_true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| pterm_in | input | NUM_PT | Logic product-term results that feed the sum |
| oe_pterm | input | 1 | Output-enable product term |
| areset_pterm | input | 1 | Array-wide asynchronous clear product term |
| spreset_pterm | input | 1 | Array-wide synchronous set product term |
| cfg_s0 | input | 1 | Polarity select: 1 active high, 0 active low |
| cfg_s1 | input | 1 | Mode select: 0 registered, 1 combinational |
| pin_in | input | 1 | Level driven onto the pin from outside while the buffer is off |
| pin_out | output | 1 | Level the cell drives toward the pin |
| pin_oe | output | 1 | Pin buffer enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complemented form |

## Verification
The assertions assume three things about the inputs. The configuration bits change only between clock edges. Once areset_pterm goes high, it stays high at least until the following rising edge. rst is high from time zero until the first edges have defined the register. The stimulus meets all three: every input is driven on the falling edge and held for a whole cycle, and the run opens with two clocks of reset before any check. The external pin level is varied against the driven level, so feedback from the wrong source shows up as a mismatch.

// File: rtl/pal_cell_pkg.sv
`timescale 1ns/1ps
package pal_cell_pkg;

    // Decoded view of the two configuration bits.
    typedef struct packed {
        logic comb_mode;    // 1: bypass the flip-flop
        logic active_high;  // 1: no inversion at the pin
    } cell_cfg_t;

    function automatic cell_cfg_t decode_cfg(input logic s0, input logic s1);
        cell_cfg_t c;
        c.comb_mode   = s1;
        c.active_high = s0;
        return c;
    endfunction

    function automatic logic polarize(input logic v, input logic active_high);
        return active_high ? v : ~v;
    endfunction

    // Product-term counts that a cell of the array may be built with.
    function automatic bit pt_count_ok(input int n);
        return (n == 8) || (n == 10) || (n == 12) || (n == 14) || (n == 16);
    endfunction

endpackage

// File: rtl/pal_sum_term.sv
`timescale 1ns/1ps
module pal_sum_term #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pterm,
    output logic              sum
);
    if (!pal_cell_pkg::pt_count_ok(NUM_PT)) begin : g_bad_count
        $error("pal_sum_term: NUM_PT must be 8, 10, 12, 14 or 16");
    end

    // R1: OR of every logic product term
    assign sum = |pterm;

endmodule

// File: rtl/pal_cell_ff.sv
`timescale 1ns/1ps
module pal_cell_ff (
    input  logic clk,
    input  logic rst,
    input  logic areset_pt,
    input  logic spreset_pt,
    input  logic d,
    output logic q
);
    // Priority: async clear, then sync reset, then sync set, then data.
    always_ff @(posedge clk or posedge areset_pt) begin
        if (areset_pt)       q <= 1'b0;
        else if (rst)        q <= 1'b0;
        else if (spreset_pt) q <= 1'b1;
        else                 q <= d;
    end

    // R6: the register reads zero whenever the clear term is high
    a_r6_async_clear: assert property (@(posedge clk) disable iff (rst)
        areset_pt |-> !q);

    // R7: a set term without a clear lands a one on the next edge
    a_r7_preset_next_edge: assert property (@(posedge clk) disable iff (rst)
        (spreset_pt && !areset_pt) |=> (q || areset_pt));

    // R9: synchronous reset leaves the register at zero
    a_r9_sync_reset: assert property (@(posedge clk) disable iff (areset_pt)
        rst |=> !q);

endmodule

// File: rtl/pal_cell_outpath.sv
`timescale 1ns/1ps
module pal_cell_outpath
    import pal_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      q,
    input  logic      oe_pt,
    input  logic      pin_in,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_true,
    output logic      fb_comp
);
    logic core;
    logic pin_side;

    always_comb begin
        core     = cfg.comb_mode ? sum : q;
        pin_out  = polarize(core, cfg.active_high);
        pin_oe   = oe_pt;
        // level seen on the pad side of the buffer
        pin_side = pin_oe ? pin_out : pin_in;
        fb_true  = cfg.comb_mode ? pin_side : ~q;
        fb_comp  = ~fb_true;
    end

endmodule

// File: rtl/pal_out_cell.sv
`timescale 1ns/1ps
module pal_out_cell
    import pal_cell_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PT-1:0] pterm_in,
    input  logic              oe_pterm,
    input  logic              areset_pterm,
    input  logic              spreset_pterm,
    input  logic              cfg_s0,
    input  logic              cfg_s1,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_true,
    output logic              fb_comp
);
    cell_cfg_t cfg;
    logic      sum;
    logic      q;

    assign cfg = decode_cfg(cfg_s0, cfg_s1);

    pal_sum_term #(.NUM_PT(NUM_PT)) u_sum (
        .pterm (pterm_in),
        .sum   (sum)
    );

    pal_cell_ff u_ff (
        .clk        (clk),
        .rst        (rst),
        .areset_pt  (areset_pterm),
        .spreset_pt (spreset_pterm),
        .d          (sum),
        .q          (q)
    );

    pal_cell_outpath u_out (
        .cfg     (cfg),
        .sum     (sum),
        .q       (q),
        .oe_pt   (oe_pterm),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_true (fb_true),
        .fb_comp (fb_comp)
    );

    // R10: registered feedback is the inverted register, which ties it to the pin through the polarity
    a_r10_reg_feedback: assert property (@(posedge clk) disable iff (rst)
        !cfg_s1 |-> (fb_true == (pin_out ^ cfg_s0)));

    // R11: a released combinational pin feeds back the external level
    a_r11_comb_feedback_ext: assert property (@(posedge clk) disable iff (rst)
        (cfg_s1 && !pin_oe) |-> (fb_true == pin_in));

    // R3: combinational output tracks the sum of the terms in the same cycle
    a_r3_comb_output: assert property (@(posedge clk) disable iff (rst)
        cfg_s1 |-> (pin_out == (cfg_s0 == (|pterm_in))));

endmodule

// File: tb/pal_out_cell_test.sv
`timescale 1ns/1ps
module pal_out_cell_test;
    localparam int NPT = 12;

    typedef struct {
        logic po;
        logic oe;
        logic fb;
        logic fbn;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NPT-1:0] pt_r = '0;
    logic           oe_r = 1'b0;
    logic           ar_r = 1'b0;
    logic           sp_r = 1'b0;
    logic           s0_r = 1'b1;
    logic           s1_r = 1'b0;
    logic           pin_r = 1'b0;
    logic           pin_out, pin_oe, fb_true, fb_comp;

    int    checks = 0;
    int    failures = 0;
    logic  mq = 1'b0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;  // 50 MHz

    pal_out_cell #(.NUM_PT(NPT)) uut (
        .clk           (clk),
        .rst           (rst),
        .pterm_in      (pt_r),
        .oe_pterm      (oe_r),
        .areset_pterm  (ar_r),
        .spreset_pterm (sp_r),
        .cfg_s0        (s0_r),
        .cfg_s1        (s1_r),
        .pin_in        (pin_r),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .fb_true       (fb_true),
        .fb_comp       (fb_comp)
    );

    // Expected pin and feedback for a given register state, from the requirements
    function automatic exp_t model_out(input logic qv);
        exp_t e;
        logic core;
        core  = s1_r ? (|pt_r) : qv;
        e.po  = s0_r ? core : ~core;
        e.oe  = oe_r;
        e.fb  = s1_r ? (oe_r ? e.po : pin_r) : ~qv;
        e.fbn = ~e.fb;
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag, input string when);
        checks++;
        if (pin_out !== e.po || pin_oe !== e.oe || fb_true !== e.fb || fb_comp !== e.fbn) begin
            failures++;
            $display("FAIL %s (%s): actual out=%b oe=%b fb=%b fbn=%b expected out=%b oe=%b fb=%b fbn=%b (R12 checked too)",
                     tag, when, pin_out, pin_oe, fb_true, fb_comp, e.po, e.oe, e.fb, e.fbn);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks the pre-edge view, queues the post-edge view
    task automatic step(input logic [NPT-1:0] pt, input logic oe, input logic ar,
                        input logic sp, input logic r, input logic pin,
                        input logic s0, input logic s1, input string tag);
        logic qpre;
        @(negedge clk);
        pt_r = pt; oe_r = oe; ar_r = ar; sp_r = sp; rst = r;
        pin_r = pin; s0_r = s0; s1_r = s1;
        #2;
        qpre = ar ? 1'b0 : mq;       // R6: clear takes effect before any edge
        compare(model_out(qpre), tag, "before edge");
        if (ar)      mq = 1'b0;
        else if (r)  mq = 1'b0;      // R9
        else if (sp) mq = 1'b1;      // R7
        else         mq = |pt;       // R1 R2
        exp_q.push_back(model_out(mq));
        tag_q.push_back(tag);
    endtask

    // Monitor: pops the expected item after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compare(e, t, "after edge");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        mq = 1'b0;
        //    pt        oe  ar  sp  rst pin s0  s1
        step(12'h000, 1, 0, 0, 1, 0, 1, 0, "R9 reset state");
        step(12'h004, 1, 0, 0, 0, 1, 1, 0, "R2 R4 R10 registered active-high one");
        step(12'h000, 1, 0, 0, 0, 1, 1, 0, "R2 R10 registered active-high zero");
        step(12'h800, 0, 0, 0, 0, 0, 1, 0, "R1 R5 top term, enable off");
        step(12'h001, 1, 0, 0, 0, 0, 0, 0, "R4 registered active-low one");
        step(12'h000, 1, 0, 0, 0, 1, 0, 0, "R4 R10 registered active-low zero");
        step(12'h020, 1, 0, 0, 0, 0, 1, 1, "R3 R11 combinational driven one");
        step(12'h000, 1, 0, 0, 0, 1, 1, 1, "R3 R11 combinational driven zero");
        step(12'h000, 0, 0, 0, 0, 1, 1, 1, "R11 R5 released, pin high");
        step(12'h400, 0, 0, 0, 0, 0, 1, 1, "R11 released, pin low");
        step(12'h010, 1, 0, 0, 0, 1, 0, 1, "R3 R4 combinational active-low");
        step(12'h000, 0, 0, 0, 0, 0, 0, 1, "R11 R12 active-low released");
        step(12'h000, 1, 0, 1, 0, 0, 1, 0, "R7 preset waits for edge");
        step(12'h000, 1, 0, 0, 0, 0, 1, 0, "R7 preset released, zero loads");
        step(12'h008, 1, 0, 0, 0, 0, 1, 0, "R2 load one");
        step(12'h008, 1, 1, 0, 0, 0, 1, 0, "R6 async clear active-high");
        step(12'h008, 1, 0, 0, 0, 0, 0, 0, "R6 reload active-low");
        step(12'h008, 1, 1, 0, 0, 0, 0, 0, "R6 async clear active-low");
        step(12'h000, 1, 0, 1, 0, 0, 1, 0, "R7 preset again");
        step(12'h000, 1, 1, 1, 0, 0, 1, 0, "R8 clear beats preset");
        step(12'h001, 1, 0, 0, 0, 0, 1, 0, "R2 recover after clear");
        step(12'h000, 1, 0, 1, 1, 0, 1, 0, "R9 reset beats preset");
        step(12'h000, 1, 0, 0, 0, 0, 1, 0, "R2 idle");
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule